// File: doc/BRIEF.md
# Rotating Bus Arbiter with Favoured Master

This block decides which of several masters owns a shared bus. Every master drives its own request line, and the arbiter drives a one-hot set of grant lines back. A grant lasts for exactly one transaction and ends when the bus returns a single-cycle done pulse. On the clock edge that ends a transaction the arbiter issues the next grant, so there is no idle cycle between owners.

Two policies are available. In round mode every requesting master gets one transaction in turn, and the search starts just past the master granted last. In favour mode one chosen master, typically a boot processor that is busy only during start-up, takes every second transaction for as long as it keeps requesting. The other masters rotate among themselves in the slots between. The policy select and the index of the favoured master are captured only while no grant is active, so a switch never splits a grant sequence in progress.

Top module: `rot_bus_arb`

## Requirements
- R1: At most one bit of `gnt_o` is high in any cycle, and a grant only goes to a master whose request was high on the edge that issued it.
- R2: A grant stays unchanged until a cycle in which `done_i` is high. On the clock edge at the end of that cycle the next grant is issued, or all grants drop if no master is requesting.
- R3: When no grant is active and exactly one master requests, that master is granted on the next clock edge.
- R4: In round mode (`fair_mode_i` = 0) the search starts at the index one above the master granted last, wraps from N-1 to 0, and takes the first requesting master.
- R5: In favour mode (`fair_mode_i` = 1) a turn flag decides whether the favoured master (`fav_idx_i`) is served next. Reset sets the flag, a favoured grant clears it, and any other grant sets it. A requesting favoured master is granted when the flag is set.
- R6: In favour mode the non-favoured masters are served by the R4 search with the favoured master masked out. The rotation pointer moves only when a non-favoured master is granted.
- R7: In favour mode, if only the favoured master requests, it is granted again and again regardless of the flag. If the favoured master does not request, the others are served back to back.
- R8: When an arbitration edge finds no request, all grants are low and the rotation pointer keeps its value. A `done_i` pulse while no grant is active has no effect.
- R9: `fair_mode_i` and `fav_idx_i` are captured only on edges where no grant is active. An arbitration started while idle uses their live values, and changes made while a grant is held are ignored until the bus goes idle.
- R10: While `rst_ni` is low all grants are low. After reset the rotation pointer is 0 and the favoured turn flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fair_mode_i | input | 1 | Policy select: 0 round, 1 favour |
| fav_idx_i | input | IDX_W | Index of the favoured master |
| req_i | input | N_MST | Request line per master |
| done_i | input | 1 | Single-cycle pulse ending the current transaction |
| gnt_o | output | N_MST | One-hot grant lines |

## Verification
The checks assume that `done_i` is a pulse of one cycle that comes only while a grant is held, and that `fav_idx_i` is below N_MST. The stimulus drives `done_i` for exactly one clock per transaction and clears it before the next vector. It uses favoured indices only inside the master range. Requests may drop while a grant is held. The hold and alternation checks therefore do not assume that the granted master keeps its request high.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    POL_ROUND  = 1'b0,
    POL_FAVOUR = 1'b1
  } arb_pol_e;
endpackage

// File: rtl/arb_rr_pick.sv
// First requester at or above ptr_i, wrapping modulo N_MST.
module arb_rr_pick #(
  parameter int N_MST = 4,
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic [N_MST-1:0] req_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int k = N_MST - 1; k >= 0; k--) begin
      int unsigned c;
      c = (int'(ptr_i) + k) % N_MST;
      if (req_i[c]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(c);
      end
    end
  end

  always_comb begin
    AST_HIT_MATCH: assert (hit_o == (|req_i)); // R4
    if (hit_o) AST_HIT_IS_REQ: assert (req_i[idx_o]); // R1
  end
endmodule

// File: rtl/arb_policy.sv
module arb_policy
  import arb_pkg::*;
#(
  parameter int N_MST = 4,
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic [N_MST-1:0] req_i,
  input  logic [IDX_W-1:0] ptr_i,
  input  arb_pol_e         pol_i,
  input  logic [IDX_W-1:0] fav_i,
  input  logic             fav_turn_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             is_fav_o
);
  logic [N_MST-1:0] fav_mask;
  logic             hit_all, hit_oth;
  logic [IDX_W-1:0] idx_all, idx_oth;

  for (genvar g = 0; g < N_MST; g++) begin : g_mask
    assign fav_mask[g] = (fav_i == IDX_W'(g));
  end

  arb_rr_pick #(.N_MST(N_MST)) u_pick_all (
    .req_i(req_i), .ptr_i(ptr_i), .hit_o(hit_all), .idx_o(idx_all)
  );

  arb_rr_pick #(.N_MST(N_MST)) u_pick_oth (
    .req_i(req_i & ~fav_mask), .ptr_i(ptr_i), .hit_o(hit_oth), .idx_o(idx_oth)
  );

  always_comb begin
    any_o    = 1'b0;
    idx_o    = '0;
    is_fav_o = 1'b0;
    if (pol_i == POL_ROUND) begin
      any_o = hit_all;
      idx_o = idx_all;
    end else if ((|(req_i & fav_mask)) && (fav_turn_i || !hit_oth)) begin
      any_o    = 1'b1;
      idx_o    = fav_i;
      is_fav_o = 1'b1;
    end else if (hit_oth) begin
      any_o = 1'b1;
      idx_o = idx_oth;
    end
  end

  always_comb begin
    if (any_o) AST_POL_PICK_REQ: assert (req_i[idx_o]); // R1
  end
endmodule

// File: rtl/rot_bus_arb.sv
module rot_bus_arb
  import arb_pkg::*;
#(
  parameter int N_MST = 4,
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fair_mode_i,
  input  logic [IDX_W-1:0] fav_idx_i,
  input  logic [N_MST-1:0] req_i,
  input  logic             done_i,
  output logic [N_MST-1:0] gnt_o
);
  logic [N_MST-1:0] gnt_q, gnt_d;
  logic [IDX_W-1:0] ptr_q, fav_q, use_fav;
  logic             fav_turn_q;
  arb_pol_e         pol_q, use_pol;
  logic             busy, arb_en;
  logic             win_any, win_fav;
  logic [IDX_W-1:0] win_idx, ptr_nxt;
  logic [N_MST-1:0] fav_mask_q;

  assign busy    = |gnt_q;
  assign arb_en  = !busy || done_i;
  // idle arbitration uses the live configuration
  assign use_pol = busy ? pol_q : arb_pol_e'(fair_mode_i);
  assign use_fav = busy ? fav_q : fav_idx_i;
  assign ptr_nxt = (win_idx == IDX_W'(N_MST - 1)) ? '0 : win_idx + 1'b1;

  arb_policy #(.N_MST(N_MST)) u_policy (
    .req_i     (req_i),
    .ptr_i     (ptr_q),
    .pol_i     (use_pol),
    .fav_i     (use_fav),
    .fav_turn_i(fav_turn_q),
    .any_o     (win_any),
    .idx_o     (win_idx),
    .is_fav_o  (win_fav)
  );

  for (genvar g = 0; g < N_MST; g++) begin : g_dec
    assign gnt_d[g]      = win_any && (win_idx == IDX_W'(g));
    assign fav_mask_q[g] = (fav_q == IDX_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q      <= '0;
      ptr_q      <= '0;
      fav_q      <= '0;
      pol_q      <= POL_ROUND;
      fav_turn_q <= 1'b1;
    end else begin
      if (!busy) begin
        pol_q <= arb_pol_e'(fair_mode_i);
        fav_q <= fav_idx_i;
      end
      if (arb_en) begin
        gnt_q <= gnt_d;
        if (win_any) begin
          if (!win_fav) ptr_q <= ptr_nxt;
          fav_turn_q <= !win_fav;
        end
      end
    end
  end

  assign gnt_o = gnt_q;

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R1
  AST_GNT_TO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_en |=> ((gnt_o & $past(req_i)) == gnt_o)); // R1
  AST_GNT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done_i) |=> (gnt_o == $past(gnt_o))); // R2
  AST_SOLE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && $onehot(req_i)) |=> (gnt_o == $past(req_i))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_en && (req_i == '0)) |=> ((gnt_o == '0) && $stable(ptr_q))); // R8
  AST_FAV_ALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && pol_q == POL_FAVOUR && |(gnt_q & fav_mask_q) && done_i
     && |(req_i & ~fav_mask_q)) |=> ((gnt_o & $past(fav_mask_q)) == '0)); // R5
  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> ($stable(pol_q) && $stable(fav_q))); // R9
endmodule

// File: tb/rot_bus_arb_bench.sv
module rot_bus_arb_bench;
  localparam int N = 4;
  localparam int NV = 26;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fair_mode_i = 1'b0;
  logic [1:0] fav_idx_i = '0;
  logic [3:0] req_i = '0;
  logic       done_i = 1'b0;
  logic [3:0] gnt_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  rot_bus_arb #(.N_MST(N)) u_rot_bus_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .fair_mode_i(fair_mode_i),
    .fav_idx_i(fav_idx_i), .req_i(req_i), .done_i(done_i), .gnt_o(gnt_o)
  );

  // {mode, fav[1:0], req[3:0], done, expected gnt[3:0]}
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 2'd0, 4'b1111, 1'b0, 4'b0001}, // 0  R4 first pick from 0
    {1'b0, 2'd0, 4'b1111, 1'b0, 4'b0001}, // 1  R2 held
    {1'b0, 2'd0, 4'b1111, 1'b1, 4'b0010}, // 2  R4
    {1'b0, 2'd0, 4'b1111, 1'b1, 4'b0100}, // 3  R4
    {1'b0, 2'd0, 4'b1111, 1'b1, 4'b1000}, // 4  R4
    {1'b0, 2'd0, 4'b1001, 1'b1, 4'b0001}, // 5  R4 wrap
    {1'b0, 2'd0, 4'b1001, 1'b1, 4'b1000}, // 6  R4 skip idle masters
    {1'b0, 2'd0, 4'b0000, 1'b1, 4'b0000}, // 7  R8
    {1'b0, 2'd0, 4'b0100, 1'b0, 4'b0100}, // 8  R3
    {1'b0, 2'd0, 4'b0011, 1'b1, 4'b0001}, // 9  R4
    {1'b0, 2'd0, 4'b0000, 1'b1, 4'b0000}, // 10 R8
    {1'b1, 2'd2, 4'b1111, 1'b0, 4'b0100}, // 11 R5 favoured first
    {1'b1, 2'd2, 4'b1111, 1'b1, 4'b0010}, // 12 R6 pointer kept at 1
    {1'b1, 2'd2, 4'b1111, 1'b1, 4'b0100}, // 13 R5
    {1'b1, 2'd2, 4'b1111, 1'b1, 4'b1000}, // 14 R6 favoured masked
    {1'b1, 2'd2, 4'b1111, 1'b1, 4'b0100}, // 15 R5
    {1'b1, 2'd2, 4'b1111, 1'b1, 4'b0001}, // 16 R6
    {1'b1, 2'd2, 4'b0100, 1'b1, 4'b0100}, // 17 R7
    {1'b1, 2'd2, 4'b0100, 1'b1, 4'b0100}, // 18 R7 alone, flag clear
    {1'b1, 2'd2, 4'b1011, 1'b1, 4'b0010}, // 19 R7 favoured absent
    {1'b1, 2'd2, 4'b1111, 1'b1, 4'b0100}, // 20 R5
    {1'b0, 2'd0, 4'b1111, 1'b0, 4'b0100}, // 21 R2 held
    {1'b0, 2'd0, 4'b1111, 1'b1, 4'b1000}, // 22 R9 mode change ignored
    {1'b0, 2'd0, 4'b0000, 1'b1, 4'b0000}, // 23 R8
    {1'b0, 2'd0, 4'b1111, 1'b0, 4'b0001}, // 24 R9 idle picks live mode
    {1'b0, 2'd0, 4'b0000, 1'b1, 4'b0000}  // 25 R8
  };

  function automatic string tag_of(int i);
    case (i)
      1, 21:             return "R2";
      8:                 return "R3";
      7, 10, 23, 25:     return "R8";
      11, 13, 15, 20:    return "R5";
      12, 14, 16:        return "R6";
      17, 18, 19:        return "R7";
      22, 24:            return "R9";
      default:           return "R4";
    endcase
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: gnt actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_r1();
    n_chk++;
    if (!$onehot0(gnt_o) || ((gnt_o & req_i) !== gnt_o)) begin
      n_bad++;
      $display("FAIL R1: gnt actual=%b expected one-hot subset of %b", gnt_o, req_i);
    end
  endtask

  // drive at a negedge, let one posedge pass, sample at the next negedge
  task automatic step(input logic m, input logic [1:0] f, input logic [3:0] r, input logic d);
    fair_mode_i = m;
    fav_idx_i   = f;
    req_i       = r;
    done_i      = d;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    req_i = 4'b1111;
    repeat (3) @(negedge clk_i);
    check("R10", gnt_o, 4'b0000); // grants low in reset
    req_i  = '0;
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [11:0] v;
      v = VEC[i];
      step(v[11], v[10:9], v[8:5], v[4]);
      check(tag_of(i), gnt_o, v[3:0]);
      check_r1();
      done_i = 1'b0;
    end

    // reset in the middle of a grant
    step(1'b0, 2'd0, 4'b1111, 1'b0);
    check("R4", gnt_o, 4'b0010); // pointer was 1
    rst_ni = 1'b0;
    #1;
    check("R10", gnt_o, 4'b0000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // flag set after reset: favoured 3 wins first
    step(1'b1, 2'd3, 4'b1111, 1'b0);
    check("R10", gnt_o, 4'b1000);
    // pointer 0 after reset
    step(1'b1, 2'd3, 4'b0111, 1'b1);
    check("R10", gnt_o, 4'b0001);
    step(1'b1, 2'd3, 4'b0000, 1'b1);
    check("R8", gnt_o, 4'b0000);
    // done while idle ignored
    step(1'b1, 2'd3, 4'b0000, 1'b1);
    check("R8", gnt_o, 4'b0000);
    step(1'b1, 2'd3, 4'b0010, 1'b0);
    check("R3", gnt_o, 4'b0010);
    step(1'b1, 2'd3, 4'b0010, 1'b0);
    check("R2", gnt_o, 4'b0010);
    step(1'b1, 2'd3, 4'b0000, 1'b1);
    check("R8", gnt_o, 4'b0000);
    done_i = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule